// File: doc/BRIEF.md
# Linked Three-Channel Compare Timer

This block holds three up-counting timer channels. Each has a counter, two compare registers (A and B) and a control register, all reached through a simple register port. The port takes single-cycle writes and gives combinational reads on a separate read address.

Channels whose link bit is set act as one group. A counter write to any linked channel loads every linked counter in the same cycle. A linked channel can also use a group clear as its clear source. It then resets whenever another linked channel clears on its own compare match. Used this way, one channel's compare-B value sets a shared period, and the other channels' compare-A values set their phases.

Each channel drives one PWM output. The output rises on a compare-A match, falls on a compare-B match, and is held low while the channel is stopped. A shared clock-enable input paces all counting.

Top module: `sync_timer_group`

## Requirements
- R1: After reset every register reads 0 and every PWM output is low.
- R2: A counter advances by 1 on each clock where its run bit is 1 and `cnt_en` is 1. Otherwise it holds its value.
- R3: With no clear firing, a counter steps from 0xFFFF to 0.
- R4: The 3-bit clear field selects the clear source: 0 = none, 1 = compare-A match, 2 = compare-B match, 3 = group clear, and 4 to 7 act as none. A compare match counts only while the channel is counting. The counter reads 0 in the cycle after the match.
- R5: A write to the counter of a linked channel loads the same value into every linked counter at the same edge.
- R6: A channel whose link bit is 0 ignores counter writes addressed to other channels and ignores group clears.
- R7: A linked channel with clear field 3 resets at the edge where any linked channel clears on its own compare match.
- R8: When a counter write and a clear fall in the same cycle, the written value is loaded.
- R9: A PWM output goes high after a compare-A match and low after a compare-B match, and compare B wins when both match. It reads low whenever the channel's run bit is 0.
- R10: Address = {channel[1:0], reg[1:0]}, where reg 0 = counter, 1 = compare A, 2 = compare B, 3 = control. Control bit 0 = run, bit 1 = link, bits 4:2 = clear field, and the upper bits read 0. Addresses of channel 3 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Shared count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data for `rd_addr` |
| pwm_out | output | 3 | PWM output per channel |

## Verification
A wrong link decision or a wrong clear decision shows up as a counter value that no longer matches the model. It is visible on the read port one cycle after the edge in question. Because every counter is read back after every edge, a lost group clear or a leaked preset is caught in that same cycle. A wrong match or a wrong PWM priority shows on `pwm_out` one cycle after the match. The bench forces a counter write into the exact cycle of a compare-B clear, so the write-over-clear priority is exercised directly.

// File: rtl/sync_timer_group.sv
module sync_timer_group #(
  parameter int NCH = 3,
  parameter int W   = 16,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_en,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [W-1:0]   rd_data,
  output logic [NCH-1:0] pwm_out
);
  localparam int CHW = AW - 2;
  localparam logic [1:0] RG_CNT = 2'd0, RG_CMPA = 2'd1, RG_CMPB = 2'd2, RG_CTRL = 2'd3;
  localparam logic [2:0] CL_A = 3'd1, CL_B = 3'd2, CL_GRP = 3'd3;

  logic [NCH-1:0][W-1:0] cnt_q, cmpa_q, cmpb_q;
  logic [NCH-1:0][2:0]   sel;
  logic [NCH-1:0]        start, sync, pwm_q, own_clr, load;

  logic [CHW-1:0] wr_ch, rd_ch;
  logic           wr_cnt, wr_tgt_sync, grp_clr;

  assign wr_ch   = wr_addr[AW-1:2];
  assign rd_ch   = rd_addr[AW-1:2];
  assign wr_cnt  = wr_en && wr_addr[1:0] == RG_CNT;
  assign grp_clr = |(own_clr & sync);

  always_comb begin
    wr_tgt_sync = 1'b0;
    rd_data     = '0;
    for (int i = 0; i < NCH; i++) begin
      if (wr_ch == CHW'(i)) wr_tgt_sync = sync[i];
      if (rd_ch == CHW'(i)) begin
        case (rd_addr[1:0])
          RG_CNT:  rd_data = cnt_q[i];
          RG_CMPA: rd_data = cmpa_q[i];
          RG_CMPB: rd_data = cmpb_q[i];
          default: rd_data = W'({sel[i], sync[i], start[i]});
        endcase
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic tick, hit_a, hit_b, self, clr;
    assign tick       = start[i] & cnt_en;
    assign hit_a      = tick && cnt_q[i] == cmpa_q[i];
    assign hit_b      = tick && cnt_q[i] == cmpb_q[i];
    assign self       = wr_ch == CHW'(i);
    assign own_clr[i] = (sel[i] == CL_A && hit_a) || (sel[i] == CL_B && hit_b);
    assign clr        = own_clr[i] || (sync[i] && sel[i] == CL_GRP && grp_clr);
    assign load[i]    = wr_cnt && (self || (sync[i] && wr_tgt_sync));
    assign pwm_out[i] = pwm_q[i] & start[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[i]  <= '0;
        cmpa_q[i] <= '0;
        cmpb_q[i] <= '0;
        sel[i]    <= '0;
        sync[i]   <= 1'b0;
        start[i]  <= 1'b0;
        pwm_q[i]  <= 1'b0;
      end else begin
        if (load[i])   cnt_q[i] <= wr_data;
        else if (clr)  cnt_q[i] <= '0;
        else if (tick) cnt_q[i] <= cnt_q[i] + 1'b1;

        if (wr_en && self) begin
          case (wr_addr[1:0])
            RG_CMPA: cmpa_q[i] <= wr_data;
            RG_CMPB: cmpb_q[i] <= wr_data;
            RG_CTRL: {sel[i], sync[i], start[i]} <= wr_data[4:0];
            default: ;
          endcase
        end

        if (!start[i])  pwm_q[i] <= 1'b0;
        else if (hit_b) pwm_q[i] <= 1'b0;
        else if (hit_a) pwm_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/timer_group_chk.sv
module timer_group_chk #(
  parameter int NCH = 3,
  parameter int W   = 16,
  parameter int AW  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cnt_en,
  input logic                  wr_en,
  input logic [AW-1:0]         wr_addr,
  input logic [W-1:0]          wr_data,
  input logic [NCH-1:0]        pwm_out,
  input logic [NCH-1:0][W-1:0] cnt_q,
  input logic [NCH-1:0][W-1:0] cmpb_q,
  input logic [NCH-1:0][2:0]   sel,
  input logic [NCH-1:0]        start,
  input logic [NCH-1:0]        sync
);
  logic any_cnt_wr;
  assign any_cnt_wr = wr_en && wr_addr[1:0] == 2'd0;

  for (genvar j = 0; j < NCH; j++) begin : g_j
    assert_pwm_low_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !start[j] |-> !pwm_out[j]);

    assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start[j] && !sync[j] && !any_cnt_wr) |=> $stable(cnt_q[j]));

    assert_own_b_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[j] == 3'd2 && start[j] && cnt_en && cnt_q[j] == cmpb_q[j] && !any_cnt_wr)
      |=> cnt_q[j] == '0);

    if (j > 0) begin : g_follow
      assert_group_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[0] == 3'd2 && sync[0] && start[0] && cnt_en && cnt_q[0] == cmpb_q[0]
         && sync[j] && sel[j] == 3'd3 && !any_cnt_wr) |=> cnt_q[j] == '0);
    end

    for (genvar k = 0; k < NCH; k++) begin : g_k
      assert_linked_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(k * 4) && sync[k] && sync[j])
        |=> cnt_q[j] == $past(wr_data));
    end
  end
endmodule

bind sync_timer_group timer_group_chk #(.NCH(NCH), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .pwm_out(pwm_out), .cnt_q(cnt_q), .cmpb_q(cmpb_q),
  .sel(sel), .start(start), .sync(sync)
);

// File: tb/sync_timer_group_tb.sv
`timescale 1ns/1ps
module sync_timer_group_tb;
  logic        clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  pwm_out;

  sync_timer_group u_dut (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_out(pwm_out));

  always #4 clk = ~clk;

  int m_cnt[3], m_a[3], m_b[3], m_sel[3];
  bit m_run[3], m_link[3], m_pwm[3];
  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit done = 0;

  function automatic int model_reg(int a);
    int ch = a / 4;
    if (ch > 2) return 0;
    case (a % 4)
      0: return m_cnt[ch];
      1: return m_a[ch];
      2: return m_b[ch];
      default: return (m_sel[ch] << 2) | (int'(m_link[ch]) << 1) | int'(m_run[ch]);
    endcase
  endfunction

  task automatic model_edge(bit we, int a, int d, bit en);
    bit own[3], hitA[3], hitB[3], grp;
    int nc[3];
    grp = 0;
    for (int i = 0; i < 3; i++) begin
      bit t = m_run[i] && en;
      hitA[i] = t && m_cnt[i] == m_a[i];
      hitB[i] = t && m_cnt[i] == m_b[i];
      own[i]  = (m_sel[i] == 1 && hitA[i]) || (m_sel[i] == 2 && hitB[i]);
      if (own[i] && m_link[i]) grp = 1;
    end
    for (int i = 0; i < 3; i++) begin
      bit ld = we && (a % 4 == 0) && (a / 4 < 3) &&
               ((a / 4 == i) || (m_link[i] && m_link[a / 4]));
      bit cl = own[i] || (m_link[i] && m_sel[i] == 3 && grp);
      if (ld) nc[i] = d;
      else if (cl) nc[i] = 0;
      else if (m_run[i] && en) nc[i] = (m_cnt[i] + 1) & 16'hFFFF;
      else nc[i] = m_cnt[i];
      if (!m_run[i]) m_pwm[i] = 0;
      else if (hitB[i]) m_pwm[i] = 0;
      else if (hitA[i]) m_pwm[i] = 1;
    end
    for (int i = 0; i < 3; i++) begin
      m_cnt[i] = nc[i];
      if (we && a / 4 == i) begin
        case (a % 4)
          1: m_a[i] = d;
          2: m_b[i] = d;
          3: begin m_run[i] = d[0]; m_link[i] = d[1]; m_sel[i] = (d >> 2) & 7; end
          default: ;
        endcase
      end
    end
  endtask

  task automatic compare_all();
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a);
      #0.05;
      n_chk++;
      if (rd_data !== 16'(model_reg(a))) begin
        n_fail++;
        $display("FAIL %s addr %0d: got %h expected %h", tag, a, rd_data, 16'(model_reg(a)));
      end
    end
    for (int i = 0; i < 3; i++) begin
      n_chk++;
      if (pwm_out[i] !== (m_pwm[i] & m_run[i])) begin
        n_fail++;
        $display("FAIL %s pwm %0d: got %b expected %b", tag, i, pwm_out[i], m_pwm[i] & m_run[i]);
      end
    end
  endtask

  task automatic step(bit we, int a, int d);
    wr_en = we; wr_addr = 4'(a); wr_data = 16'(d);
    @(posedge clk);
    model_edge(we, a, d, cnt_en);
    #1;
    compare_all();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0);
  endtask

  function automatic int ctl(int s, bit lk, bit run);
    return (s << 2) | (int'(lk) << 1) | int'(run);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    foreach (m_cnt[i]) begin
      m_cnt[i] = 0; m_a[i] = 0; m_b[i] = 0; m_sel[i] = 0;
      m_run[i] = 0; m_link[i] = 0; m_pwm[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; compare_all();

    tag = "R10";
    step(1, 1, 2);  step(1, 2, 9);
    step(1, 5, 4);  step(1, 6, 7);
    step(1, 9, 6);  step(1, 10, 8);
    step(1, 13, 16'h1234); step(1, 15, 16'hFFFF);
    step(1, 7, 16'hFFE0 | ctl(3, 1, 0));
    step(1, 11, ctl(3, 1, 0));
    cnt_en = 1'b1;
    step(1, 3, ctl(2, 1, 1));
    step(1, 7, ctl(3, 1, 1));
    step(1, 11, ctl(3, 1, 1));

    tag = "R7"; idle(30);
    tag = "R2"; cnt_en = 1'b0; idle(4); cnt_en = 1'b1; idle(5);
    tag = "R5"; step(1, 4, 3); idle(8);

    tag = "R8";
    for (int k = 0; k < 20 && m_cnt[0] != 9; k++) idle(1);
    step(1, 0, 5); idle(6);

    tag = "R6";
    step(1, 11, ctl(3, 0, 1));
    step(1, 0, 1); idle(25);
    step(1, 8, 16'h0100); idle(4);

    tag = "R3";
    step(1, 11, ctl(0, 0, 1));
    step(1, 8, 16'hFFFD); idle(6);

    tag = "R4";
    step(1, 9, 3); step(1, 11, ctl(1, 0, 1)); step(1, 8, 0); idle(10);
    step(1, 11, ctl(5, 0, 1)); step(1, 8, 0); idle(12);

    tag = "R9";
    step(1, 9, 3); step(1, 10, 3); step(1, 11, ctl(0, 0, 1)); step(1, 8, 0); idle(6);
    step(1, 3, ctl(2, 1, 0)); idle(5);
    step(1, 3, ctl(2, 1, 1)); idle(12);

    finish_run();
  end
endmodule